// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, side A and side B. Each transfer direction has its own holding register, and each register has its own capture strobe. On the driven side, a source multiplexer places either the live data from the opposite bus or the held copy. An active-low enable and a direction input choose which side is driven, if either is. When the enable is released, both sides float, but both holding registers still take data from their own bus on each strobe edge.

The bidirectional pins are split into an input vector, an output vector and an output-enable vector for each bus, so the block can be synthesized and a pad ring or tri-state wrapper can sit outside it. The capture strobes are sampled on the system clock, and a capture happens on each low-to-high change that is seen. The `INVERT` parameter builds the variant that drives the complement of the selected data. The holding registers always store true data.

Top module: `regbus_xcvr`

## Requirements
- R1: A synchronous active-low reset clears both holding registers to zero. After reset, with the enable low, `dir_a2b`=1 and `sel_ab`=1, `b_out` shows 8'h00 (8'hFF when INVERT=1).
- R2: In the first system-clock cycle in which `cap_ab` is sampled 1 after being sampled 0, the A-to-B register loads `a_in`. The new value appears on `b_out` from the next cycle when `sel_ab`=1.
- R3: In the first system-clock cycle in which `cap_ba` is sampled 1 after being sampled 0, the B-to-A register loads `b_in`. The new value appears on `a_out` from the next cycle when `sel_ba`=1.
- R4: While `en_n`=1 (isolation), `a_oe`, `b_oe`, `a_out` and `b_out` are all zero, whatever `dir_a2b` and the selects are.
- R5: While `en_n`=0 and `dir_a2b`=1, `b_oe` is all ones, and `a_oe` and `a_out` are all zero.
- R6: While `en_n`=0 and `dir_a2b`=0, `a_oe` is all ones, and `b_oe` and `b_out` are all zero.
- R7: With B driven and `sel_ab`=0, `b_out` follows `a_in` in the same cycle, with no register in the path.
- R8: With A driven and `sel_ba`=0, `a_out` follows `b_in` in the same cycle.
- R9: Strobe edges load the holding registers during isolation and also in the direction that is not driven. A value captured that way appears on the output when that output is later driven in stored mode.
- R10: With INVERT=1, each driven output is the bitwise complement of the selected source. The stored values are not inverted, so a held byte comes out complemented exactly once.
- R11: A strobe that stays high loads the register only once. Changes on the bus while the strobe is held high do not alter the stored value.
- R12: `a_oe` and `b_oe` are never both non-zero in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_n | input | 1 | Output enable, active low |
| dir_a2b | input | 1 | 1: drive B from A; 0: drive A from B |
| sel_ab | input | 1 | B source: 0 live A, 1 held A-to-B register |
| sel_ba | input | 1 | A source: 0 live B, 1 held B-to-A register |
| cap_ab | input | 1 | A-to-B capture strobe, acts on its rising edge |
| cap_ba | input | 1 | B-to-A capture strobe, acts on its rising edge |
| a_in | input | 8 | Data received from bus A |
| a_out | output | 8 | Data to drive onto bus A |
| a_oe | output | 8 | Per-bit drive enable for bus A |
| b_in | input | 8 | Data received from bus B |
| b_out | output | 8 | Data to drive onto bus B |
| b_oe | output | 8 | Per-bit drive enable for bus B |

## Verification
The bench builds two copies of the block that share every input: one with INVERT=0 and one with INVERT=1. Both are compared each cycle against a reference model kept inside the bench. With the shared stimulus, the same captured byte can be seen as true data on one copy and as its complement on the other. This shows that the inversion is applied only at the output and never to the stored value. The default width of 8 is used, so each byte pattern in the stimulus table reaches every bit lane.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef struct packed {
    logic drive_a;
    logic drive_b;
  } drive_t;

  // Which side is driven, given the active-low enable and direction
  function automatic drive_t decode_drive(input logic en_n, input logic dir_a2b);
    drive_t d;
    d.drive_a = ~en_n & ~dir_a2b;
    d.drive_b = ~en_n &  dir_a2b;
    return d;
  endfunction

  // Strobe edge: sampled high now, low on the previous sample
  function automatic logic rise(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
  import xcvr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_n,
  input  logic dir_a2b,
  output logic drive_a,
  output logic drive_b
);
  drive_t dec;

  always_comb begin
    dec     = decode_drive(en_n, dir_a2b);
    drive_a = dec.drive_a;
    drive_b = dec.drive_b;
  end

  // R12
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_a && drive_b));

  // R4
  iso_nodrive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> (!drive_a && !drive_b));

endmodule

// File: rtl/xcvr_hold_reg.sv
module xcvr_hold_reg
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic strobe_q;
  logic cap_evt;

  assign cap_evt = rise(strobe, strobe_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      if (cap_evt) q <= d;
    end
  end

  // R2 R3
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (q == $past(d)));

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && strobe_q) |=> $stable(q));

endmodule

// File: rtl/xcvr_out_path.sv
module xcvr_out_path #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drive,
  input  logic         sel_held,
  input  logic [W-1:0] live,
  input  logic [W-1:0] held,
  output logic [W-1:0] out,
  output logic [W-1:0] oe
);
  localparam logic [W-1:0] FLIP = INVERT ? {W{1'b1}} : {W{1'b0}};

  logic [W-1:0] src;

  function automatic logic [W-1:0] pick(input logic s, input logic [W-1:0] l,
                                        input logic [W-1:0] h);
    return s ? h : l;
  endfunction

  always_comb begin
    src = pick(sel_held, live, held);
    out = drive ? (src ^ FLIP) : '0;
    oe  = {W{drive}};
  end

  // R5 R6
  oe_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> (oe == {W{1'b1}}));

  // R4
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> (oe == '0 && out == '0));

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_n,
  input  logic         dir_a2b,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  logic         drive_a;
  logic         drive_b;
  logic [W-1:0] held_ab;
  logic [W-1:0] held_ba;

  xcvr_dir_ctrl u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_n    (en_n),
    .dir_a2b (dir_a2b),
    .drive_a (drive_a),
    .drive_b (drive_b)
  );

  xcvr_hold_reg #(.W(W)) u_reg_ab (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cap_ab),
    .d      (a_in),
    .q      (held_ab)
  );

  xcvr_hold_reg #(.W(W)) u_reg_ba (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cap_ba),
    .d      (b_in),
    .q      (held_ba)
  );

  xcvr_out_path #(.W(W), .INVERT(INVERT)) u_path_b (
    .clk      (clk),
    .rst_n    (rst_n),
    .drive    (drive_b),
    .sel_held (sel_ab),
    .live     (a_in),
    .held     (held_ab),
    .out      (b_out),
    .oe       (b_oe)
  );

  xcvr_out_path #(.W(W), .INVERT(INVERT)) u_path_a (
    .clk      (clk),
    .rst_n    (rst_n),
    .drive    (drive_a),
    .sel_held (sel_ba),
    .live     (b_in),
    .held     (held_ba),
    .out      (a_out),
    .oe       (a_oe)
  );

  // R12
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|a_oe) && (|b_oe)));

  // R4
  iso_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> (a_oe == '0 && b_oe == '0));

endmodule

// File: tb/regbus_xcvr_tb.sv
module regbus_xcvr_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       en_n = 1'b1, dir_a2b = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic       cap_ab = 1'b0, cap_ba = 1'b0;
  logic [7:0] a_in = '0, b_in = '0;
  logic [7:0] a_out0, a_oe0, b_out0, b_oe0;
  logic [7:0] a_out1, a_oe1, b_out1, b_oe1;

  int checks = 0;
  int errors = 0;

  regbus_xcvr #(.W(8), .INVERT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir_a2b(dir_a2b),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .a_in(a_in), .a_out(a_out0), .a_oe(a_oe0),
    .b_in(b_in), .b_out(b_out0), .b_oe(b_oe0));

  regbus_xcvr #(.W(8), .INVERT(1'b1)) u_dut_inv (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir_a2b(dir_a2b),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .a_in(a_in), .a_out(a_out1), .a_oe(a_oe1),
    .b_in(b_in), .b_out(b_out1), .b_oe(b_oe1));

  // reference model
  logic [7:0] m_ab = '0, m_ba = '0;
  logic       m_pab = 1'b0, m_pba = 1'b0;

  // vector: {en_n, dir_a2b, sel_ab, sel_ba, cap_ab, cap_ba, a_in, b_in}
  localparam int NV = 16;
  localparam logic [21:0] VEC [NV] = '{
    {6'b100000, 8'h11, 8'h22},
    {6'b100011, 8'h33, 8'h44},
    {6'b010000, 8'hA5, 8'h00},
    {6'b011000, 8'h0F, 8'h00},
    {6'b011010, 8'hC3, 8'h00},
    {6'b011010, 8'h77, 8'h00},
    {6'b011000, 8'h77, 8'h00},
    {6'b000000, 8'h00, 8'h5A},
    {6'b000100, 8'h00, 8'h99},
    {6'b000101, 8'h00, 8'hE1},
    {6'b000100, 8'h00, 8'h00},
    {6'b001000, 8'h00, 8'h3C},
    {6'b111110, 8'hAA, 8'h00},
    {6'b011100, 8'h12, 8'h00},
    {6'b000001, 8'h00, 8'hFF},
    {6'b000100, 8'h00, 8'h00}
  };

  function automatic string tag_of(input logic inv);
    if (inv)             return "R10";
    if (en_n)            return "R4";
    if (dir_a2b)         return sel_ab ? "R2/R5" : "R7/R5";
    return sel_ba ? "R3/R6" : "R8/R6";
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_inst(input logic inv, input logic [7:0] ao, input logic [7:0] aoe,
                            input logic [7:0] bo, input logic [7:0] boe);
    logic [7:0] flip, e_ao, e_aoe, e_bo, e_boe;
    logic da, db;
    string t;
    flip  = inv ? 8'hFF : 8'h00;
    da    = !en_n && !dir_a2b;
    db    = !en_n &&  dir_a2b;
    e_aoe = {8{da}};
    e_boe = {8{db}};
    e_ao  = da ? ((sel_ba ? m_ba : b_in) ^ flip) : 8'h00;
    e_bo  = db ? ((sel_ab ? m_ab : a_in) ^ flip) : 8'h00;
    t = tag_of(inv);
    checks++;
    if ({ao, aoe, bo, boe} !== {e_ao, e_aoe, e_bo, e_boe}) begin
      errors++;
      $display("FAIL %s ports actual=%h/%h/%h/%h expected=%h/%h/%h/%h",
               t, ao, aoe, bo, boe, e_ao, e_aoe, e_bo, e_boe);
    end
    // R12
    if ((|aoe) && (|boe)) begin
      errors++;
      $display("FAIL R12 both enables actual=%h/%h expected=one zero", aoe, boe);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_ab = '0; m_ba = '0; m_pab = 1'b0; m_pba = 1'b0;
    end else begin
      if (cap_ab && !m_pab) m_ab = a_in;
      if (cap_ba && !m_pba) m_ba = b_in;
      m_pab = cap_ab;
      m_pba = cap_ba;
    end
  endtask

  task automatic apply(input logic [21:0] v);
    @(negedge clk);
    {en_n, dir_a2b, sel_ab, sel_ba, cap_ab, cap_ba, a_in, b_in} = v;
    #5;
    check_inst(1'b0, a_out0, a_oe0, b_out0, b_oe0);
    check_inst(1'b1, a_out1, a_oe1, b_out1, b_oe1);
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) begin
      @(posedge clk);
      model_edge();
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: registers cleared by reset
    apply({6'b011100, 8'h00, 8'h00});
    cmp("R1", "b_out after reset", b_out0, 8'h00);
    cmp("R1", "b_out inv after reset", b_out1, 8'hFF);

    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // R9: capture in isolation then show it
    apply({6'b100010, 8'h5A, 8'h00});
    apply({6'b011000, 8'h00, 8'h00});
    cmp("R9", "held via isolation", b_out0, 8'h5A);
    cmp("R10", "held inverted once", b_out1, 8'hA5);

    // R11: strobe held high does not reload
    apply({6'b011010, 8'h3E, 8'h00});
    apply({6'b011010, 8'hC1, 8'h00});
    apply({6'b011000, 8'h00, 8'h00});
    cmp("R11", "no reload on held strobe", b_out0, 8'h3E);

    // R7: live path same cycle
    apply({6'b010000, 8'h96, 8'h00});
    cmp("R7", "live A to B", b_out0, 8'h96);

    // R3: B-to-A capture while B is driven (R9 other direction)
    apply({6'b010001, 8'h00, 8'h6D});
    apply({6'b000100, 8'h00, 8'h00});
    cmp("R3", "held B to A", a_out0, 8'h6D);

    // R4: isolation with every other control set
    apply({6'b111100, 8'hFF, 8'hFF});
    cmp("R4", "a_oe isolated", a_oe0, 8'h00);
    cmp("R4", "b_out isolated", b_out1, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule